// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After a start pulse this block walks a configuration image held in a serial EEPROM and turns it into register writes. It fetches the image one byte at a time through a byte-read request/response handshake, which stands in for the serial bus master. It decodes the typed blocks it finds and drives a write port with a doubleword system address, a 32-bit data word and a one-cycle strobe.

While it reads, the block keeps an 8-bit additive checksum over every byte. When it reaches the end-of-image block it raises done and reports whether the checksum came out as all ones. An ignore input can mask the checksum error. An unknown block type halts the load at once and raises a format error.

Top module: `cfg_image_loader`

## Requirements
- R1: Every load reads the EEPROM from byte address 0 upward, one address per accepted handshake (a cycle with `rd_req_o` and `rd_ack_i` both high), with no gap and no repeat. A later start begins again at address 0.
- R2: Block header byte 0 holds the block kind in bits 1:0 and system address bits 7:2 in bits 7:2. Header byte 1 bits 5:0 hold system address bits 13:8, and its bits 7:6 are ignored. `wr_addr_o` bits 1:0 are always 0.
- R3: Kind 0 (single) is followed by four data bytes, least significant byte first. It produces exactly one write of that word to the header address.
- R4: Kind 1 (sequential) carries a 16-bit doubleword count in bytes 2 and 3, low byte first, followed by that many words, each least significant byte first. Word n is written to the header address plus 4n. A count of 0 produces no write.
- R5: Kind 2 (end) is three bytes long: the header byte, an unused byte and a checksum-balance byte. In the cycle after the handshake of its last byte, `done_o` is 1 and `busy_o` is 0.
- R6: When the 8-bit sum of every byte read, the end block included, differs from 0xFF, `sum_err_o` is 1 together with `done_o`. Otherwise it is 0.
- R7: While `ignore_sum_i` is 1, `sum_err_o` stays 0 whatever the sum is.
- R8: Kind 3 (reserved) stops the load at that header byte. No further read or write follows, and `fmt_err_o` and `done_o` become 1.
- R9: `busy_o` is 1 from the cycle after an accepted start until done. A start while busy is ignored. Each `wr_en_o` pulse lasts one cycle.
- R10: After reset, `busy_o`, `done_o`, `rd_req_o`, `wr_en_o`, `sum_err_o` and `fmt_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-load pulse |
| ignore_sum_i | input | 1 | Mask the checksum error |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | ROM_AW | EEPROM byte address |
| rd_ack_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 8 | Read data byte |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | SA_W | System byte address of the write |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished |
| sum_err_o | output | 1 | Checksum mismatch |
| fmt_err_o | output | 1 | Reserved block kind met |

## Verification
The hardest cases to reach are the ones where the image itself is wrong: a reserved kind byte in the middle of an image, or a sum that misses 0xFF by one. In both, the halt point and the exact count of bytes fetched matter. The bench builds every image byte by byte from small block-writing tasks that keep a running sum, so the balance byte is computed rather than written out by hand. It places a reserved header between valid blocks and checks that the handshake count stops right at that header. The memory model grants only every other request and checks each requested address against its own counter, so stalls and the address sequence are exercised on every load.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
   typedef enum logic [1:0] {
      BK_ONE = 2'd0,
      BK_SEQ = 2'd1,
      BK_END = 2'd2,
      BK_RSV = 2'd3
   } blk_kind_e;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_TYPE,
      PS_AHI,
      PS_CLO,
      PS_CHI,
      PS_DATA,
      PS_TAIL
   } pstate_e;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 32;
   localparam int SUM_OK = 8'hFF;
endpackage

// File: rtl/cfg_ldr_fetch.sv
module cfg_ldr_fetch #(
   parameter int ROM_AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              active_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic [ROM_AW-1:0] addr_o,
   output logic              take_o
);
   assign req_o  = active_i;
   assign take_o = active_i & ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_o <= '0;
      else if (start_i) addr_o <= '0;
      else if (take_o)  addr_o <= addr_o + 1'b1;
   end

   // R1: each accepted byte moves the address by exactly one
   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/cfg_ldr_sum.sv
module cfg_ldr_sum (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       take_i,
   input  logic [7:0] byte_i,
   output logic [7:0] sum_next_o
);
   logic [7:0] sum_q;

   assign sum_next_o = take_i ? sum_q + byte_i : sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (clr_i) sum_q <= '0;
      else            sum_q <= sum_next_o;
   end
endmodule

// File: rtl/cfg_ldr_parse.sv
module cfg_ldr_parse
   import cfg_ldr_pkg::*;
#(
   parameter int SA_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            take_i,
   input  logic [7:0]      byte_i,
   output logic            active_o,
   output logic            fin_o,
   output logic            fmt_o,
   output logic            wr_en_o,
   output logic [SA_W-1:0] wr_addr_o,
   output logic [31:0]     wr_data_o
);
   localparam int WA_W = SA_W - 2;
   localparam int HI_W = SA_W - 8;

   pstate_e          st;
   blk_kind_e        kind;
   logic [WA_W-1:0]  wadr;
   logic [WA_W-1:0]  wr_wadr;
   logic [15:0]      left;
   logic [1:0]       lane;
   logic [31:0]      dat;
   logic [31:0]      word_nx;

   assign active_o  = (st != PS_IDLE);
   assign word_nx   = {byte_i, dat[31:8]};
   assign wr_addr_o = {wr_wadr, 2'b00};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= PS_IDLE;
         kind      <= BK_ONE;
         wadr      <= '0;
         wr_wadr   <= '0;
         left      <= '0;
         lane      <= '0;
         dat       <= '0;
         wr_data_o <= '0;
         wr_en_o   <= 1'b0;
         fin_o     <= 1'b0;
         fmt_o     <= 1'b0;
      end else begin
         wr_en_o <= 1'b0;
         fin_o   <= 1'b0;
         fmt_o   <= 1'b0;
         if (start_i && st == PS_IDLE) begin
            st <= PS_TYPE;
         end else if (take_i) begin
            case (st)
               PS_TYPE: begin
                  kind      <= blk_kind_e'(byte_i[1:0]);
                  wadr[5:0] <= byte_i[7:2];
                  if (blk_kind_e'(byte_i[1:0]) == BK_RSV) begin
                     st    <= PS_IDLE;
                     fmt_o <= 1'b1;
                  end else begin
                     st <= PS_AHI;
                  end
               end
               PS_AHI: begin
                  wadr[WA_W-1:6] <= byte_i[HI_W-1:0];
                  lane           <= '0;
                  case (kind)
                     BK_ONE: begin left <= 16'd1; st <= PS_DATA; end
                     BK_SEQ: st <= PS_CLO;
                     default: st <= PS_TAIL;
                  endcase
               end
               PS_CLO: begin
                  left[7:0] <= byte_i;
                  st        <= PS_CHI;
               end
               PS_CHI: begin
                  left[15:8] <= byte_i;
                  st <= ({byte_i, left[7:0]} == 16'd0) ? PS_TYPE : PS_DATA;
               end
               PS_DATA: begin
                  dat  <= word_nx;
                  lane <= lane + 2'd1;
                  if (lane == 2'd3) begin
                     wr_en_o   <= 1'b1;
                     wr_data_o <= word_nx;
                     wr_wadr   <= wadr;
                     wadr      <= wadr + 1'b1;
                     left      <= left - 16'd1;
                     if (left == 16'd1) st <= PS_TYPE;
                  end
               end
               PS_TAIL: begin
                  st    <= PS_IDLE;
                  fin_o <= 1'b1;
               end
               default: st <= PS_IDLE;
            endcase
         end
      end
   end

   // R9: a write strobe never lasts two cycles
   p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);
   // R4: back-to-back words of one block land on consecutive doublewords
   p_seq_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && st == PS_DATA) |-> (wadr == wr_wadr + 1'b1));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
   import cfg_ldr_pkg::*;
#(
   parameter int ROM_AW = 16,
   parameter int SA_W   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ignore_sum_i,
   output logic              rd_req_o,
   output logic [ROM_AW-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [7:0]        rd_data_i,
   output logic              wr_en_o,
   output logic [SA_W-1:0]   wr_addr_o,
   output logic [31:0]       wr_data_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              sum_err_o,
   output logic              fmt_err_o
);
   generate
      if (SA_W < 9 || SA_W > 16) begin : g_bad_sa
         $error("SA_W must lie in 9..16");
      end
      if (ROM_AW < 2 || ROM_AW > 32) begin : g_bad_aw
         $error("ROM_AW must lie in 2..32");
      end
   endgenerate

   logic       active, take, fin, fmt, start_ok;
   logic [7:0] sum_nx;

   assign start_ok = start_i & ~active;
   assign busy_o   = active;

   cfg_ldr_fetch #(.ROM_AW(ROM_AW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .start_i(start_ok), .active_i(active),
      .ack_i(rd_ack_i), .req_o(rd_req_o), .addr_o(rd_addr_o), .take_o(take));

   cfg_ldr_sum u_sum (
      .clk(clk), .rst_n(rst_n), .clr_i(start_ok), .take_i(take),
      .byte_i(rd_data_i), .sum_next_o(sum_nx));

   cfg_ldr_parse #(.SA_W(SA_W)) u_parse (
      .clk(clk), .rst_n(rst_n), .start_i(start_ok), .take_i(take),
      .byte_i(rd_data_i), .active_o(active), .fin_o(fin), .fmt_o(fmt),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

   // status is captured on the handshake that ends the image
   logic fin_now, fmt_now;
   assign fin_now = take && (u_parse.st == PS_TAIL);
   assign fmt_now = take && (u_parse.st == PS_TYPE) && (rd_data_i[1:0] == 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         sum_err_o <= 1'b0;
         fmt_err_o <= 1'b0;
      end else if (start_ok) begin
         done_o    <= 1'b0;
         sum_err_o <= 1'b0;
         fmt_err_o <= 1'b0;
      end else begin
         if (fin_now || fmt_now) done_o <= 1'b1;
         if (fmt_now) fmt_err_o <= 1'b1;
         if (fin_now) sum_err_o <= (sum_nx != 8'(SUM_OK)) && !ignore_sum_i;
      end
   end

   // R5: done and busy are never high together
   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R8: after a format error nothing more is fetched
   p_fmt_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_o |-> (!rd_req_o && done_o));
   // R7: a masked checksum never reports
   p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && $past(ignore_sum_i)) |-> !sum_err_o);
   // R5: the parser's end pulse coincides with done rising
   p_fin_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (done_o && !fmt_err_o));
   // R9: a fetch is only requested while busy
   p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> busy_o);
   // R8: the format pulse and the done-block pulse are exclusive
   p_fmt_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt |-> (fmt_err_o && !fin));
endmodule

// File: tb/cfg_image_loader_test.sv
`timescale 1ns/1ps
module cfg_image_loader_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        ignore_sum_i = 1'b0;
   logic        rd_req_o;
   logic [15:0] rd_addr_o;
   logic        rd_ack_i = 1'b0;
   logic [7:0]  rd_data_i = 8'h00;
   logic        wr_en_o;
   logic [13:0] wr_addr_o;
   logic [31:0] wr_data_o;
   logic        busy_o, done_o, sum_err_o, fmt_err_o;

   always #2.5 clk = ~clk;

   cfg_image_loader uut (.*);

   int nchk = 0;
   int nfail = 0;

   // stimulus table: {word address[11:0], data[31:0]}
   localparam logic [43:0] VEC [0:7] = '{
      44'h010_A5A5_0001, 44'h200_1111_0000, 44'h201_2222_1111,
      44'h202_3333_2222, 44'h203_4444_3333, 44'h204_5555_4444,
      44'hFC3_DEAD_BEEF, 44'h03F_8000_0001 };

   logic [7:0]  mem [0:255];
   int          wp;
   logic [7:0]  s;
   logic        phase = 1'b0;
   int          exp_rd, addr_bad, nacks, nw;
   logic [13:0] cap_a [0:15];
   logic [31:0] cap_d [0:15];

   // memory model: grants every other request and checks the address order
   always @(negedge clk) begin
      phase <= ~phase;
      if (rd_req_o && phase) begin
         if (int'(rd_addr_o) != exp_rd) addr_bad = addr_bad + 1;
         exp_rd = exp_rd + 1;
         nacks  = nacks + 1;
      end
      rd_ack_i  <= rd_req_o & phase;
      rd_data_i <= mem[rd_addr_o[7:0]];
      if (wr_en_o && nw < 16) begin
         cap_a[nw] = wr_addr_o;
         cap_d[nw] = wr_data_o;
      end
      if (wr_en_o) nw = nw + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk = nchk + 1;
      if (!ok) begin
         nfail = nfail + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic img_clear();
      for (int i = 0; i < 256; i++) mem[i] = 8'h03;
      wp = 0;
      s  = 8'h00;
   endtask

   task automatic put(input logic [7:0] b);
      mem[wp] = b;
      s  = s + b;
      wp = wp + 1;
   endtask

   // header bits 7:6 of byte 1 are filled with ones: they must be ignored (R2)
   task automatic hdr(input logic [1:0] k, input logic [11:0] w);
      put({w[5:0], k});
      put({2'b11, w[11:6]});
   endtask

   task automatic dw(input logic [31:0] d);
      put(d[7:0]); put(d[15:8]); put(d[23:16]); put(d[31:24]);
   endtask

   task automatic end_blk(input bit good);
      logic [7:0] b;
      put(8'h02);
      put(8'h00);
      b = good ? (8'hFF - s) : (8'hFE - s);
      put(b);
   endtask

   task automatic run(input bit poke);
      int t;
      nw = 0; exp_rd = 0; nacks = 0; addr_bad = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(busy_o == 1'b1, "R9 busy after start", 64'(busy_o), 64'd1);
      if (poke) begin
         repeat (20) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      t = 0;
      while (!done_o && t < 5000) begin
         @(negedge clk);
         t = t + 1;
      end
      chk(t < 5000, "watchdog", 64'(t), 64'd5000);
   endtask

   task automatic img_main(input bit good);
      img_clear();
      hdr(2'd0, VEC[0][43:32]); dw(VEC[0][31:0]);
      hdr(2'd1, VEC[1][43:32]); put(8'd5); put(8'd0);
      for (int i = 1; i <= 5; i++) dw(VEC[i][31:0]);
      hdr(2'd0, VEC[6][43:32]); dw(VEC[6][31:0]);
      hdr(2'd0, VEC[7][43:32]); dw(VEC[7][31:0]);
      end_blk(good);
   endtask

   initial begin
      #(200000 * 5);
      nfail = nfail + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      img_clear();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk({busy_o, done_o, rd_req_o, wr_en_o, sum_err_o, fmt_err_o} == 6'b0,
          "R10 reset outputs", 64'({busy_o, done_o, rd_req_o, wr_en_o, sum_err_o, fmt_err_o}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({busy_o, done_o, rd_req_o} == 3'b0, "R10 idle after reset",
          64'({busy_o, done_o, rd_req_o}), 64'd0);

      // main image, with a start pulse while busy (R9)
      img_main(1'b1);
      run(1'b1);
      chk(nw == 8, "R3 R4 R9 write count", 64'(nw), 64'd8);
      for (int i = 0; i < 8; i++) begin
         chk(cap_a[i] == {VEC[i][43:32], 2'b00}, "R2 R4 write address",
             64'(cap_a[i]), 64'({VEC[i][43:32], 2'b00}));
         chk(cap_d[i] == VEC[i][31:0], "R3 R4 write data", 64'(cap_d[i]), 64'(VEC[i][31:0]));
      end
      chk(addr_bad == 0, "R1 sequential reads from 0", 64'(addr_bad), 64'd0);
      chk(nacks == wp, "R5 bytes read", 64'(nacks), 64'(wp));
      chk(busy_o == 1'b0 && done_o == 1'b1, "R5 done and idle", 64'({busy_o, done_o}), 64'd1);
      chk(sum_err_o == 1'b0, "R6 good sum", 64'(sum_err_o), 64'd0);
      chk(fmt_err_o == 1'b0, "R8 no format error", 64'(fmt_err_o), 64'd0);

      // bad checksum
      img_main(1'b0);
      run(1'b0);
      chk(sum_err_o == 1'b1, "R6 bad sum flagged", 64'(sum_err_o), 64'd1);
      chk(addr_bad == 0, "R1 restart at address 0", 64'(addr_bad), 64'd0);

      // bad checksum masked
      ignore_sum_i = 1'b1;
      run(1'b0);
      chk(sum_err_o == 1'b0, "R7 ignore masks sum", 64'(sum_err_o), 64'd0);
      chk(done_o == 1'b1, "R7 done with ignore", 64'(done_o), 64'd1);
      ignore_sum_i = 1'b0;

      // zero-count sequential block
      img_clear();
      hdr(2'd1, 12'h300); put(8'd0); put(8'd0);
      hdr(2'd0, 12'h123); dw(32'hCAFE_F00D);
      end_blk(1'b1);
      run(1'b0);
      chk(nw == 1, "R4 zero count writes nothing", 64'(nw), 64'd1);
      chk(cap_a[0] == 14'h048C && cap_d[0] == 32'hCAFE_F00D, "R3 after empty block",
          64'({cap_a[0], cap_d[0]}), 64'({14'h048C, 32'hCAFE_F00D}));
      chk(sum_err_o == 1'b0, "R6 sum zero count", 64'(sum_err_o), 64'd0);

      // reserved block kind in the middle
      img_clear();
      hdr(2'd0, 12'h001); dw(32'h0000_0001);
      put(8'h07);
      hdr(2'd0, 12'h002); dw(32'h0000_0002);
      end_blk(1'b1);
      run(1'b0);
      repeat (6) @(negedge clk);
      chk(fmt_err_o == 1'b1 && done_o == 1'b1, "R8 format error", 64'({fmt_err_o, done_o}), 64'd3);
      chk(nw == 1, "R8 no write after reserved", 64'(nw), 64'd1);
      chk(nacks == 7, "R8 reads stop at reserved", 64'(nacks), 64'd7);
      chk(rd_req_o == 1'b0 && busy_o == 1'b0, "R8 halted", 64'({rd_req_o, busy_o}), 64'd0);

      // restart clears the format flag
      img_main(1'b1);
      run(1'b0);
      chk(fmt_err_o == 1'b0 && nw == 8, "R1 R8 restart clean", 64'({fmt_err_o, 8'(nw)}), 64'd8);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule